// File: doc/BRIEF.md
# Interval and Free-Run Timer Channel

A single timer channel on a plain synchronous register port. Software loads a compare value and picks one of two modes. In interval mode the channel counts down from the compare value and raises a one-clock interrupt pulse at a fixed period. In free-run mode it counts up from zero across the full counter range and raises a pulse each time the count equals the compare value. Free-run mode therefore serves both as a monotonic time base (compare left at zero) and as a one-shot event source (compare set to a delta, then stopped from the interrupt handler).

Counting is started and stopped by writing to two separate trigger registers rather than by a control bit. A read-only status bit reports whether the channel is running. After a stop request this bit stays set until the stop has actually taken effect, so software can poll it before reprogramming. Compare and control values written while the channel runs are stored at once, but the counter only uses them at the next start.

Top module: `tmr_channel`

## Requirements
- R1: Byte offsets: compare 0x000 (read/write, low CNT_W bits), counter 0x004 (read-only), status 0x010 (read-only, bit 0 = running), start trigger 0x014 and stop trigger 0x018 (write-only), control 0x020 (read/write, 8 bits). Compare and control read back what was written. The trigger offsets read as zero.
- R2: A write with data bit 0 = 1 to the start trigger while the channel is stopped starts it, and status bit 0 reads 1 from the clock after the write. A write with bit 0 = 0 has no effect.
- R3: A write with bit 0 = 1 to the stop trigger leaves status bit 0 at 1 for the two clocks after the write edge, and status reads 0 from the third. After that the counter value no longer changes and the interrupt stays low.
- R4: With control bit 1 = 0 (interval mode) a start loads compare C into the counter, which then decrements once per clock. The interrupt pulses first C+1 clocks after the start edge and then once every C+1 clocks, each pulse lasting one clock when C is at least 1.
- R5: With control bit 1 = 1 (free-run mode) a start clears the counter to 0. It then rises by one per clock and wraps from all-ones back to zero.
- R6: In free-run mode the interrupt pulses for one clock in the clock after the counter equals compare D, and counting continues. The first pulse therefore comes D+1 clocks after the start edge.
- R7: A start-trigger write while the channel is running, including while a stop is pending, is ignored: the counter is not reloaded and the pending stop still completes.
- R8: Compare and control writes made while running change the registers at once. The counter uses them only from the next start.
- R9: Synchronous active-high reset clears compare, control and counter, leaves the channel stopped and holds the interrupt low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | ADDR_W | Register byte offset |
| busWe | input | 1 | Write strobe |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data of the addressed register (combinational) |
| irqOut | output | 1 | Interrupt pulse |

## Verification
A wrong live compare, mode or count shows at the interrupt pin as a period or first-pulse delay that is off by at least one clock. It shows within one interval, or within compare+1 clocks of a start. A stuck or mistimed stop sequencer shows in the status read within three clocks of the stop write, and as a counter that still moves afterwards. An accidental reload on a repeated start shows in the very next counter read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Register byte offsets; software depends on these positions.
  localparam logic [7:0] OFF_CMP   = 8'h00;
  localparam logic [7:0] OFF_CNT   = 8'h04;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_START = 8'h14;
  localparam logic [7:0] OFF_STOP  = 8'h18;
  localparam logic [7:0] OFF_CTRL  = 8'h20;

  // Control bit that selects free-run mode.
  localparam int CTRL_FREE_BIT = 1;

  // Number of clocks a stop request is held pending.
  localparam int STOP_LAT = 2;

  typedef struct packed {
    logic startLoad;  // latch compare/mode and preset counter
    logic runEn;      // channel running, advance counter
  } tmr_strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  cmpReg,
  output logic              freeSel,
  output tmr_strobe_t       strobes
);
  localparam int SD_W = $clog2(STOP_LAT + 1);

  logic [7:0]      ctrlReg;
  logic            running;
  logic [SD_W-1:0] stopDly;

  logic selCmp, selCnt, selStat, selStart, selStop, selCtrl;
  logic startHit, stopHit, startLoad;

  assign selCmp   = busAddr == ADDR_W'(OFF_CMP);
  assign selCnt   = busAddr == ADDR_W'(OFF_CNT);
  assign selStat  = busAddr == ADDR_W'(OFF_STAT);
  assign selStart = busAddr == ADDR_W'(OFF_START);
  assign selStop  = busAddr == ADDR_W'(OFF_STOP);
  assign selCtrl  = busAddr == ADDR_W'(OFF_CTRL);

  assign startHit  = busWe && selStart && busWdata[0];
  assign stopHit   = busWe && selStop && busWdata[0];
  assign startLoad = startHit && !running;

  assign freeSel   = ctrlReg[CTRL_FREE_BIT];
  assign strobes.startLoad = startLoad;
  assign strobes.runEn     = running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpReg  <= '0;
      ctrlReg <= '0;
      running <= 1'b0;
      stopDly <= '0;
    end else begin
      if (busWe && selCmp)  cmpReg  <= busWdata[CNT_W-1:0];
      if (busWe && selCtrl) ctrlReg <= busWdata[7:0];
      if (startLoad) running <= 1'b1;
      if (stopDly != '0) begin
        if (stopDly == SD_W'(STOP_LAT)) begin
          stopDly <= '0;
          running <= 1'b0;
        end else begin
          stopDly <= stopDly + 1'b1;
        end
      end else if (stopHit && running) begin
        stopDly <= SD_W'(1);
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (selCmp)       busRdata = DATA_W'(cmpReg);
    else if (selCnt)  busRdata = DATA_W'(cntVal);
    else if (selStat) busRdata = DATA_W'(running);
    else if (selCtrl) busRdata = DATA_W'(ctrlReg);
  end

  // R2
  start_runs_chk: assert property (@(posedge clk) disable iff (rst)
    startLoad |=> running);
  // R3
  stop_done_chk: assert property (@(posedge clk) disable iff (rst)
    (stopDly == SD_W'(STOP_LAT)) |=> !running);
  // R3
  stop_held_chk: assert property (@(posedge clk) disable iff (rst)
    (stopHit && running && stopDly == '0) |=> running);
  // R7
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (startHit && running && stopDly == '0) |=> running);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_strobe_t      strobes,
  input  logic [CNT_W-1:0] cmpReg,
  input  logic             freeSel,
  output logic [CNT_W-1:0] cntVal,
  output logic             irqOut
);
  logic [CNT_W-1:0] cmpLive;
  logic             freeLive;
  logic             hit;

  assign hit = freeLive ? (cntVal == cmpLive) : (cntVal == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cntVal   <= '0;
      cmpLive  <= '0;
      freeLive <= 1'b0;
      irqOut   <= 1'b0;
    end else if (strobes.startLoad) begin
      cmpLive  <= cmpReg;
      freeLive <= freeSel;
      cntVal   <= freeSel ? '0 : cmpReg;
      irqOut   <= 1'b0;
    end else if (strobes.runEn) begin
      irqOut <= hit;
      if (freeLive)  cntVal <= cntVal + 1'b1;
      else if (hit)  cntVal <= cmpLive;
      else           cntVal <= cntVal - 1'b1;
    end else begin
      irqOut <= 1'b0;
    end
  end

  // R3
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.runEn && !strobes.startLoad) |=> $stable(cntVal));
  // R5
  upcount_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.runEn && !strobes.startLoad && freeLive)
      |=> cntVal == $past(cntVal) + 1'b1);
  // R4
  downcount_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.runEn && !strobes.startLoad && !freeLive && cntVal != '0)
      |=> cntVal == $past(cntVal) - 1'b1);
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (irqOut && freeLive && CNT_W > 1) |=> !irqOut);
  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irqOut && cntVal == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  tmr_strobe_t      strobes;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] cmpReg;
  logic             freeSel;

  tmr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .cntVal(cntVal),
    .cmpReg(cmpReg), .freeSel(freeSel), .strobes(strobes)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .cmpReg(cmpReg),
    .freeSel(freeSel), .cntVal(cntVal), .irqOut(irqOut)
  );
endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, busRdata8;
  logic        irqOut, irqOut8;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_channel u_dut (.clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut));

  tmr_channel #(.CNT_W(8)) u_dut8 (.clk(clk), .rst(rst), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata8), .irqOut(irqOut8));

  function automatic int expIntervalGap(int c); return c + 1; endfunction
  function automatic int expFreeFirst(int d);   return d + 1; endfunction

  task automatic check(string tag, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(logic [7:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(logic [7:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic busRd8(logic [7:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata8;
  endtask

  task automatic waitIrq(output int k);
    k = 0;
    for (int i = 1; i <= 5000; i++) begin
      @(negedge clk);
      if (irqOut) begin k = i; break; end
    end
  endtask

  task automatic stopAll();
    busWr(8'h18, 32'h1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, v;
    int k, c, d, seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    busRd(8'h00, r); check("R9 compare after reset", r, 0);
    busRd(8'h04, r); check("R9 counter after reset", r, 0);
    busRd(8'h10, r); check("R9 status after reset", r, 0);
    busRd(8'h20, r); check("R9 control after reset", r, 0);
    check("R9 irq after reset", irqOut, 0);

    // R1 read-back and trigger reads
    v = $urandom;
    busWr(8'h00, v);     busRd(8'h00, r); check("R1 compare readback", r, v);
    busWr(8'h20, 32'hA5); busRd(8'h20, r); check("R1 control readback", r, 32'hA5);
    busRd(8'h14, r); check("R1 start trigger reads zero", r, 0);
    busRd(8'h18, r); check("R1 stop trigger reads zero", r, 0);

    // R2 start with bit0=0 is ignored
    busWr(8'h14, 32'hFE); busRd(8'h10, r); check("R2 bit0 clear no start", r, 0);

    // R4 interval mode, random compare values
    for (int it = 0; it < 4; it++) begin
      c = 1 + ($urandom % 40);
      busWr(8'h20, 32'h0); busWr(8'h00, c);
      busWr(8'h14, 32'h1);
      busRd(8'h10, r); check("R2 status after start", r, 1);
      waitIrq(k); check("R4 first interval pulse", k, expIntervalGap(c));
      @(negedge clk); check("R4 pulse one clock", irqOut, 0);
      waitIrq(k); check("R4 interval period", k + 1, expIntervalGap(c));
      stopAll();
    end

    // R6 free-run delta events
    for (int it = 0; it < 3; it++) begin
      d = 2 + ($urandom % 60);
      busWr(8'h20, 32'h2); busWr(8'h00, d);
      busWr(8'h14, 32'h1);
      waitIrq(k); check("R6 free-run first event", k, expFreeFirst(d));
      busRd(8'h04, r); check("R6 counting continues", r, d + 1);
      @(negedge clk); check("R6 pulse one clock", irqOut, 0);
      stopAll();
    end

    // R5 monotonic time base with compare 0
    busWr(8'h20, 32'h2); busWr(8'h00, 32'h0);
    busWr(8'h14, 32'h1);
    busRd(8'h04, r); check("R5 counter zero at start", r, 0);
    repeat (5) @(negedge clk);
    busRd(8'h04, r); check("R5 counter increments", r, 5);

    // R7 start while running ignored
    busWr(8'h14, 32'h1);
    busRd(8'h04, r); check("R7 no reload on restart", r, 6);

    // R3 stop latency and freeze
    busWr(8'h18, 32'h1);
    busRd(8'h10, r); check("R3 status held clock 1", r, 1);
    @(negedge clk); busRd(8'h10, r); check("R3 status held clock 2", r, 1);
    @(negedge clk); busRd(8'h10, r); check("R3 status clears clock 3", r, 0);
    busRd(8'h04, v);
    repeat (4) @(negedge clk);
    busRd(8'h04, r); check("R3 counter frozen", r, v);
    check("R3 irq low when stopped", irqOut, 0);

    // R7 start during pending stop ignored
    busWr(8'h14, 32'h1);
    busWr(8'h18, 32'h1);
    busWr(8'h14, 32'h1);
    busRd(8'h10, r); check("R7 stop still pending", r, 1);
    @(negedge clk); busRd(8'h10, r); check("R7 pending stop completes", r, 0);

    // R8 writes while running apply at next start
    busWr(8'h20, 32'h0); busWr(8'h00, 32'd5);
    busWr(8'h14, 32'h1);
    busWr(8'h00, 32'd20); busWr(8'h20, 32'h2);
    waitIrq(k); waitIrq(k);
    check("R8 period unchanged while running", k, expIntervalGap(5));
    stopAll();
    busWr(8'h14, 32'h1);
    waitIrq(k); check("R8 new settings at restart", k, expFreeFirst(20));
    stopAll();

    // R5 wrap on the narrow instance
    busWr(8'h20, 32'h2); busWr(8'h00, 32'h0);
    busWr(8'h14, 32'h1);
    repeat (255) @(negedge clk);
    busRd8(8'h04, r); check("R5 narrow counter all-ones", r, 255);
    @(negedge clk);
    busRd8(8'h04, r); check("R5 narrow counter wraps", r, 0);
    @(negedge clk);
    check("R6 event after wrap", irqOut8, 1);
    stopAll();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule